// File: doc/BRIEF.md
# Timer capture unit with prescaled edge select

This block takes a snapshot of a free-running timer when a chosen event appears on an external pin. The pin is synchronized into the clock domain and passed to an edge detector. A four-bit mode value, written through a simple write strobe, selects one of four events: a falling edge, a rising edge, every fourth rising edge, or every sixteenth rising edge. When the selected event occurs, the whole timer word is copied into a capture register and a sticky interrupt-request flag is raised.

Software reads the captured word through a read strobe. It clears the flag with a separate clear strobe, because reading does not clear it. A newer capture always replaces an older value that has not been read. The all-zero mode, and every mode code that is not a capture mode, stops capturing and resets the edge history and the prescaler. Leaving that idle state can therefore raise a false capture. Software is expected to clear the flag after any mode change.

Top module: `capt_unit`

## Requirements
- R1: After reset the flag is 0, the capture register and the read data are 0, and the mode is 0000 (idle).
- R2: In mode 0100, each falling edge of the pin causes a capture and no rising edge does.
- R3: In mode 0101, each rising edge of the pin causes a capture and no falling edge does.
- R4: In mode 0110, only every fourth rising edge causes a capture. The 1st, 2nd and 3rd rising edges after the count starts leave the flag clear, and the 4th sets it.
- R5: In mode 0111, only every sixteenth rising edge causes a capture.
- R6: A capture copies the timer input as sampled on the clock edge three rising clock edges after the pin changes (the first sampling edge counts as one), and sets the flag on that same edge.
- R7: The flag stays set until a clear strobe is given, and is 0 on the cycle after a clear when no capture coincides with it. A read strobe does not clear it.
- R8: A capture that arrives before the previous value was read overwrites the capture register.
- R9: Any mode write resets the prescaler count, so in mode 0110 four fresh rising edges are needed after the write.
- R10: Mode 0000 and every code whose upper two bits are not 01 (for example 1000) produce no capture on any pin edge.
- R11: In idle modes the edge history is held low. A write from idle to mode 0101 while the pin is already high therefore raises a capture one cycle after the write.
- R12: A capture and a clear strobe in the same cycle leave the flag set.
- R13: A read strobe loads the read data port with the capture register on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Free-running timer value |
| pin_in | input | 1 | Asynchronous event pin |
| mode_wr_en | input | 1 | Mode write strobe |
| mode_wr_data | input | 4 | Mode value to write |
| cap_rd_en | input | 1 | Capture register read strobe |
| cap_rd_data | output | 16 | Read data, loaded one cycle after the strobe |
| irq_flag | output | 1 | Sticky capture interrupt request |
| irq_clr | input | 1 | Flag clear strobe |

## Verification
On every cycle, the assertions check the following: a captured word equals the timer value of the capture cycle, and the capture register and the flag change only after a capture. They also check the priority between a capture and a clear, and that the prescaler count is zero after any mode write. Only the bench scenarios can show which pin edges count as events in each mode. The same holds for the 4 and 16 prescale ratios and the restart after a rewrite. The scenarios also cover the silence of idle codes, the false capture on leaving idle with the pin high, and the overwrite of an unread value.

// File: rtl/capt_pkg.sv
package capt_pkg;
    localparam int MODE_W   = 4;
    localparam int PRE_MAX  = 16;
    localparam int CNT_W    = $clog2(PRE_MAX);

    localparam logic [1:0] CAP_GROUP = 2'b01;

    typedef enum logic [1:0] {
        SEL_FALL  = 2'b00,
        SEL_RISE  = 2'b01,
        SEL_RISE4 = 2'b10,
        SEL_RISE16 = 2'b11
    } edge_sel_e;

    function automatic logic [CNT_W-1:0] pre_limit(input edge_sel_e sel);
        case (sel)
            SEL_RISE4:  pre_limit = CNT_W'(4 - 1);
            SEL_RISE16: pre_limit = CNT_W'(PRE_MAX - 1);
            default:    pre_limit = '0;
        endcase
    endfunction

    function automatic logic is_capture(input logic [MODE_W-1:0] m);
        is_capture = (m[MODE_W-1:MODE_W-2] == CAP_GROUP);
    endfunction
endpackage

// File: rtl/capt_sync.sv
module capt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/capt_event.sv
module capt_event
    import capt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              mode_wr_i,
    output logic              fire_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic      active, rise, fall;
    edge_sel_e sel;

    always_comb begin
        active = is_capture(mode_i);
        sel    = edge_sel_e'(mode_i[1:0]);
        rise   = sync_i & ~st_q.prev;
        fall   = ~sync_i & st_q.prev;
        fire_o = 1'b0;
        st_d   = st_q;

        st_d.prev = active ? sync_i : 1'b0;

        if (active) begin
            if (sel == SEL_FALL) begin
                fire_o = fall;
            end else if (rise) begin
                fire_o = (st_q.cnt == pre_limit(sel));
                st_d.cnt = fire_o ? '0 : st_q.cnt + 1'b1;
            end
        end

        if (mode_wr_i || !active) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/capt_unit.sv
module capt_unit
    import capt_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  tmr_val,
    input  logic              pin_in,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    input  logic              cap_rd_en,
    output logic [TMR_W-1:0]  cap_rd_data,
    output logic              irq_flag,
    input  logic              irq_clr
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [TMR_W-1:0]  cap;
        logic [TMR_W-1:0]  rd;
        logic              flag;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic        pin_sync;
    logic        cap_fire;

    capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    capt_event u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (pin_sync),
        .mode_i    (st_q.mode),
        .mode_wr_i (mode_wr_en),
        .fire_o    (cap_fire)
    );

    always_comb begin
        st_d = st_q;
        if (mode_wr_en) st_d.mode = mode_wr_data;
        if (cap_fire)   st_d.cap  = tmr_val;
        if (cap_rd_en)  st_d.rd   = st_q.cap;
        if (cap_fire)     st_d.flag = 1'b1;
        else if (irq_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_rd_data = st_q.rd;
    assign irq_flag    = st_q.flag;

    // R6
    cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (st_q.cap == $past(tmr_val)));

    // R8
    cap_only_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cap) |-> $past(cap_fire));

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(cap_fire));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cap_fire) |=> !irq_flag);

    // R12
    fire_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && irq_clr) |=> irq_flag);
endmodule

// File: tb/sim_capt_unit.sv
`timescale 1ns/1ps
module sim_capt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_val = '0;
    logic        pin_in = 1'b0;
    logic        mode_wr_en = 1'b0;
    logic [3:0]  mode_wr_data = '0;
    logic        cap_rd_en = 1'b0;
    logic [15:0] cap_rd_data;
    logic        irq_flag;
    logic        irq_clr = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    capt_unit u0 (
        .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .pin_in(pin_in),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .cap_rd_en(cap_rd_en), .cap_rd_data(cap_rd_data),
        .irq_flag(irq_flag), .irq_clr(irq_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pin_set(input logic v);
        @(negedge clk) pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_pin();
        pin_set(1'b1);
        pin_set(1'b0);
    endtask

    task automatic write_mode(input logic [3:0] m);
        @(negedge clk) begin mode_wr_en = 1'b1; mode_wr_data = m; end
        @(posedge clk);
        @(negedge clk) mode_wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk) irq_clr = 1'b0;
    endtask

    task automatic read_cap(output logic [15:0] v);
        @(negedge clk) cap_rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk) cap_rd_en = 1'b0;
        v = cap_rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check(irq_flag == 1'b0, "R1 flag", irq_flag, 0);
        check(cap_rd_data == 16'h0, "R1 rd_data", cap_rd_data, 0);
        read_cap(v);
        check(v == 16'h0, "R1 capture reg", v, 0);
    endtask

    task automatic t_rise();
        logic [15:0] v;
        write_mode(4'b0101);
        tmr_val = 16'h1234;
        pin_set(1'b1);
        check(irq_flag == 1'b1, "R3 rise sets flag", irq_flag, 1);
        read_cap(v);
        check(v == 16'h1234, "R6 captured word", v, 16'h1234);
        check(irq_flag == 1'b1, "R7 read keeps flag", irq_flag, 1);
        read_cap(v);
        check(cap_rd_data == 16'h1234, "R13 read port", cap_rd_data, 16'h1234);
        clear_flag();
        check(irq_flag == 1'b0, "R7 clear", irq_flag, 0);
        tmr_val = 16'h5555;
        pin_set(1'b0);
        check(irq_flag == 1'b0, "R3 fall ignored", irq_flag, 0);
    endtask

    task automatic t_fall();
        logic [15:0] v;
        write_mode(4'b0100);
        tmr_val = 16'h0A0A;
        pin_set(1'b1);
        check(irq_flag == 1'b0, "R2 rise ignored", irq_flag, 0);
        tmr_val = 16'hBEEF;
        pin_set(1'b0);
        check(irq_flag == 1'b1, "R2 fall sets flag", irq_flag, 1);
        read_cap(v);
        check(v == 16'hBEEF, "R2 captured word", v, 16'hBEEF);
        clear_flag();
    endtask

    task automatic t_pre4();
        logic [15:0] v;
        write_mode(4'b0110);
        clear_flag();
        for (int i = 0; i < 8; i++) begin
            tmr_val = 16'(100 + i);
            pulse_pin();
            if (i < 3)
                check(irq_flag == 1'b0, "R4 early edge", irq_flag, 0);
            else if (i == 3) begin
                check(irq_flag == 1'b1, "R4 fourth edge", irq_flag, 1);
                read_cap(v);
                check(v == 16'd103, "R4 value", v, 103);
            end
        end
        read_cap(v);
        check(v == 16'd107, "R8 overwrite", v, 107);
        clear_flag();
    endtask

    task automatic t_pre16();
        logic [15:0] v;
        write_mode(4'b0111);
        clear_flag();
        for (int i = 0; i < 16; i++) begin
            tmr_val = 16'(16'h200 + i);
            pulse_pin();
            if (i == 14)
                check(irq_flag == 1'b0, "R5 fifteenth edge", irq_flag, 0);
        end
        check(irq_flag == 1'b1, "R5 sixteenth edge", irq_flag, 1);
        read_cap(v);
        check(v == 16'h20F, "R5 value", v, 16'h20F);
        clear_flag();
    endtask

    task automatic t_restart();
        write_mode(4'b0110);
        clear_flag();
        pulse_pin();
        pulse_pin();
        write_mode(4'b0110);
        for (int i = 0; i < 3; i++) pulse_pin();
        check(irq_flag == 1'b0, "R9 count restarted", irq_flag, 0);
        pulse_pin();
        check(irq_flag == 1'b1, "R9 fourth after rewrite", irq_flag, 1);
        clear_flag();
    endtask

    task automatic t_idle();
        write_mode(4'b0000);
        clear_flag();
        pulse_pin();
        check(irq_flag == 1'b0, "R10 idle code", irq_flag, 0);
        write_mode(4'b1000);
        pulse_pin();
        check(irq_flag == 1'b0, "R10 non-capture code", irq_flag, 0);
    endtask

    task automatic t_spurious();
        logic [15:0] v;
        write_mode(4'b0000);
        clear_flag();
        pin_set(1'b1);
        tmr_val = 16'h7777;
        write_mode(4'b0101);
        check(irq_flag == 1'b0, "R11 no flag on write edge", irq_flag, 0);
        @(posedge clk);
        @(negedge clk);
        check(irq_flag == 1'b1, "R11 false capture", irq_flag, 1);
        read_cap(v);
        check(v == 16'h7777, "R11 value", v, 16'h7777);
        pin_set(1'b0);
        clear_flag();
    endtask

    task automatic t_same_cycle();
        write_mode(4'b0101);
        clear_flag();
        @(negedge clk) pin_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk) irq_clr = 1'b0;
        check(irq_flag == 1'b1, "R12 capture wins", irq_flag, 1);
        pin_set(1'b0);
        clear_flag();
        check(irq_flag == 1'b0, "R7 clear after", irq_flag, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_rise();
        t_fall();
        t_pre4();
        t_pre16();
        t_restart();
        t_idle();
        t_spurious();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule